// File: doc/BRIEF.md
# Video Frame Start and Framing Error Monitor

This block watches a video pixel stream and decides where each frame begins. The frame start comes from one of two selectable sources. The first is the start-of-frame marker the stream carries on its first beat. The second is an external sync pulse, which is high for one clock and starts the frame on its falling edge. On every start the block emits a one-cycle strobe and clears its per-frame line and byte counters. It then follows the frame by counting accepted beats against a programmed line length (bytes) and frame height (lines).

Two sticky error flags report framing faults. The early flag rises when a new start, from either source, lands before the current frame has delivered all its lines. The size flag rises in two cases: when a frame is cut short by such an early start, and when a frame is started with a programmed width or height of zero. A one-cycle clear input drops both flags.

The monitor never stalls the stream. Both `s_valid` and `s_ready` are inputs, and a beat is counted only in a cycle where both are high. With `s_ready` low the stream may hold its data for any number of cycles, and no beat is counted. Sizes and the source select come in as plain inputs and are expected to stay stable while a frame is running.

Top module: `vfrm_guard`

## Requirements
- R1: While `rst_n` is low, `frm_start`, `err_early`, `err_size`, `line_cnt` and `byte_cnt` are all zero.
- R2: With `cfg_src`=0, a beat (`s_valid` and `s_ready` both high) carrying `s_sof`=1 starts a frame: `frm_start` is high for exactly the next cycle and that beat is counted as the frame's first. In this mode `ext_sync` has no effect.
- R3: With `cfg_src`=1, a frame starts in the first cycle in which `ext_sync` is low after being high; `frm_start` is high in the following cycle. In this mode `s_sof` has no effect on starts.
- R4: Only beats count: each beat inside an active frame adds BPB = DATA_W/8 to `byte_cnt`. A cycle with `s_valid` or `s_ready` low changes no counter.
- R5: A line closes on a beat with `s_last`=1, or on the beat at which the bytes accumulated in the line reach `cfg_hsize`, whichever comes first. Each closed line increments `line_cnt`.
- R6: When `line_cnt` reaches `cfg_vsize` the frame is complete. Later beats change no counter until the next start.
- R7: A start that arrives while the current frame is incomplete sets both `err_early` and `err_size`. A start after a complete frame sets neither.
- R8: A start with `cfg_hsize`=0 or `cfg_vsize`=0 sets `err_size`, and leaves no active frame, so its beats are not counted.
- R9: Both error flags hold their value until `err_clr` is high for a cycle, which clears them. When a new error and `err_clr` fall in the same cycle, the error wins.
- R10: Every start resets `line_cnt` and `byte_cnt`. The starting beat, if any and if the frame is active, is then counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 1 | Frame start source: 0 stream marker, 1 external sync |
| cfg_hsize | input | HSIZE_W | Line length in bytes |
| cfg_vsize | input | VSIZE_W | Lines per frame |
| ext_sync | input | 1 | External one-cycle frame sync pulse |
| err_clr | input | 1 | One-cycle clear of both error flags |
| s_valid | input | 1 | Stream beat valid |
| s_ready | input | 1 | Stream beat accepted by the sink |
| s_last | input | 1 | End-of-line marker |
| s_sof | input | 1 | Start-of-frame marker on a frame's first beat |
| frm_start | output | 1 | One-cycle frame start strobe |
| err_early | output | 1 | Sticky start-before-frame-complete error |
| err_size | output | 1 | Sticky size error (short frame or zero size) |
| line_cnt | output | VSIZE_W | Lines closed in the current frame |
| byte_cnt | output | HSIZE_W+VSIZE_W | Bytes accepted in the current frame |

## Verification
The assertions assume the external sync is a clean pulse sampled in the stream clock domain. They also assume that the sizes and the source select do not change during a frame, because the byte-step and line checks compare against the live size inputs. The stimulus holds `ext_sync` high for exactly one idle cycle per pulse. It changes `cfg_src`, `cfg_hsize` and `cfg_vsize` only between frames or just before a start. All inputs are driven half a cycle away from the sampling edge.

// File: rtl/vfrm_pkg.sv
package vfrm_pkg;
  typedef enum logic {
    SRC_STREAM = 1'b0,
    SRC_EXT    = 1'b1
  } vfrm_src_e;

  function automatic int unsigned beat_bytes(input int unsigned data_w);
    return data_w / 8;
  endfunction
endpackage

// File: rtl/vfrm_start_sel.sv
module vfrm_start_sel
  import vfrm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic ext_sync,
  input  logic beat,
  input  logic sof,
  output logic start_ev
);
  logic sync_q;
  logic sync_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= ext_sync;
  end

  assign sync_fall = sync_q & ~ext_sync;

  always_comb begin
    if (vfrm_src_e'(src) == SRC_EXT) start_ev = sync_fall;
    else                             start_ev = beat & sof;
  end
endmodule

// File: rtl/vfrm_track.sv
module vfrm_track #(
  parameter int HSIZE_W = 16,
  parameter int VSIZE_W = 13,
  parameter int BPB     = 4,
  localparam int LB_W   = HSIZE_W + 1,
  localparam int BC_W   = HSIZE_W + VSIZE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ev,
  input  logic               beat,
  input  logic               last,
  input  logic [HSIZE_W-1:0] hsize,
  input  logic [VSIZE_W-1:0] vsize,
  output logic [VSIZE_W-1:0] line_cnt,
  output logic [BC_W-1:0]    byte_cnt,
  output logic               early_ev,
  output logic               zero_ev
);
  logic               active_q, active_n, eff_act, zero_sz;
  logic [LB_W-1:0]    lb_q, lb_n, base_lb, nb;
  logic [VSIZE_W-1:0] lc_n, base_lc, lc_inc;
  logic [BC_W-1:0]    bc_n, base_bc;

  assign zero_sz  = (hsize == '0) | (vsize == '0);
  assign early_ev = start_ev & active_q;
  assign zero_ev  = start_ev & zero_sz;

  assign eff_act = start_ev ? ~zero_sz : active_q;
  assign base_lb = start_ev ? '0 : lb_q;
  assign base_lc = start_ev ? '0 : line_cnt;
  assign base_bc = start_ev ? '0 : byte_cnt;
  assign nb      = base_lb + LB_W'(BPB);
  assign lc_inc  = base_lc + 1'b1;

  always_comb begin
    active_n = eff_act;
    lb_n     = base_lb;
    lc_n     = base_lc;
    bc_n     = base_bc;
    if (beat && eff_act) begin
      bc_n = base_bc + BC_W'(BPB);
      if (last || (nb >= {1'b0, hsize})) begin
        lb_n = '0;
        lc_n = lc_inc;
        if (lc_inc == vsize) active_n = 1'b0;
      end else begin
        lb_n = nb;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      lb_q     <= '0;
      line_cnt <= '0;
      byte_cnt <= '0;
    end else begin
      active_q <= active_n;
      lb_q     <= lb_n;
      line_cnt <= lc_n;
      byte_cnt <= bc_n;
    end
  end
endmodule

// File: rtl/vfrm_flags.sv
module vfrm_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NFLAG-1:0] set,
  output logic [NFLAG-1:0] flag
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr)    flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vfrm_guard.sv
module vfrm_guard
  import vfrm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HSIZE_W = 16,
  parameter int VSIZE_W = 13,
  localparam int BPB    = DATA_W / 8,
  localparam int BC_W   = HSIZE_W + VSIZE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_src,
  input  logic [HSIZE_W-1:0] cfg_hsize,
  input  logic [VSIZE_W-1:0] cfg_vsize,
  input  logic               ext_sync,
  input  logic               err_clr,
  input  logic               s_valid,
  input  logic               s_ready,
  input  logic               s_last,
  input  logic               s_sof,
  output logic               frm_start,
  output logic               err_early,
  output logic               err_size,
  output logic [VSIZE_W-1:0] line_cnt,
  output logic [BC_W-1:0]    byte_cnt
);
  logic       beat, start_ev, early_ev, zero_ev;
  logic [1:0] flag_set, flag_q;

  assign beat = s_valid & s_ready;

  vfrm_start_sel u_start (
    .clk(clk), .rst_n(rst_n), .src(cfg_src), .ext_sync(ext_sync),
    .beat(beat), .sof(s_sof), .start_ev(start_ev)
  );

  vfrm_track #(.HSIZE_W(HSIZE_W), .VSIZE_W(VSIZE_W), .BPB(BPB)) u_track (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .beat(beat), .last(s_last),
    .hsize(cfg_hsize), .vsize(cfg_vsize), .line_cnt(line_cnt),
    .byte_cnt(byte_cnt), .early_ev(early_ev), .zero_ev(zero_ev)
  );

  assign flag_set = {early_ev | zero_ev, early_ev};

  vfrm_flags #(.NFLAG(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .set(flag_set), .flag(flag_q)
  );

  assign err_early = flag_q[0];
  assign err_size  = flag_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frm_start <= 1'b0;
    else        frm_start <= start_ev;
  end
endmodule

// File: rtl/vfrm_guard_chk.sv
module vfrm_guard_chk #(
  parameter int DATA_W  = 32,
  parameter int HSIZE_W = 16,
  parameter int VSIZE_W = 13,
  localparam int BPB    = DATA_W / 8,
  localparam int BC_W   = HSIZE_W + VSIZE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_src,
  input logic [HSIZE_W-1:0] cfg_hsize,
  input logic [VSIZE_W-1:0] cfg_vsize,
  input logic               ext_sync,
  input logic               err_clr,
  input logic               s_valid,
  input logic               s_ready,
  input logic               s_last,
  input logic               s_sof,
  input logic               frm_start,
  input logic               err_early,
  input logic               err_size,
  input logic [VSIZE_W-1:0] line_cnt,
  input logic [BC_W-1:0]    byte_cnt
);
  logic sync_d, start_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_d <= 1'b0;
    else        sync_d <= ext_sync;
  end

  assign start_c = cfg_src ? (sync_d & ~ext_sync) : (s_valid & s_ready & s_sof);

  assert_stream_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_src && s_valid && s_ready && s_sof) |=> frm_start);

  assert_ext_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src && sync_d && !ext_sync) |=> frm_start);

  assert_no_spurious_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_c |=> !frm_start);

  assert_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |-> (byte_cnt == $past(byte_cnt)) ||
                   (byte_cnt == $past(byte_cnt) + BC_W'(BPB)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_start && !$past(s_valid && s_ready)) |-> $stable(byte_cnt));

  assert_early_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_early) |-> $past(start_c));

  assert_zero_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && $past(cfg_hsize == '0)) |-> err_size);

  assert_early_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_early) && !$past(err_clr)) |-> err_early);

  assert_size_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_size) && !$past(err_clr)) |-> err_size);
endmodule

bind vfrm_guard vfrm_guard_chk #(
  .DATA_W(DATA_W), .HSIZE_W(HSIZE_W), .VSIZE_W(VSIZE_W)
) u_chk (.*);

// File: tb/vfrm_guard_tb.sv
module vfrm_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 16;
  localparam int VW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_src = 1'b0;
  logic [HW-1:0] cfg_hsize = 16'd8;
  logic [VW-1:0] cfg_vsize = 13'd2;
  logic          ext_sync = 1'b0, err_clr = 1'b0;
  logic          s_valid = 1'b0, s_ready = 1'b0, s_last = 1'b0, s_sof = 1'b0;
  logic          frm_start, err_early, err_size;
  logic [VW-1:0] line_cnt;
  logic [HW+VW-1:0] byte_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfrm_guard #(.DATA_W(32), .HSIZE_W(HW), .VSIZE_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_hsize(cfg_hsize),
    .cfg_vsize(cfg_vsize), .ext_sync(ext_sync), .err_clr(err_clr),
    .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last), .s_sof(s_sof),
    .frm_start(frm_start), .err_early(err_early), .err_size(err_size),
    .line_cnt(line_cnt), .byte_cnt(byte_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle of inputs just after a falling edge, return at the next one
  task automatic step(input logic v, input logic r, input logic l, input logic s);
    s_valid = v; s_ready = r; s_last = l; s_sof = s;
    @(negedge clk);
    s_valid = 1'b0; s_ready = 1'b0; s_last = 1'b0; s_sof = 1'b0;
    err_clr = 1'b0; ext_sync = 1'b0;
  endtask

  task automatic expect_state(input string req, input int st, input int lc,
                              input int bc, input int ee, input int es);
    check({req, " frm_start"}, int'(frm_start), st);
    check({req, " line_cnt"},  int'(line_cnt),  lc);
    check({req, " byte_cnt"},  int'(byte_cnt),  bc);
    check({req, " err_early"}, int'(err_early), ee);
    check({req, " err_size"},  int'(err_size),  es);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    s_valid = 1'b1; s_ready = 1'b1; s_sof = 1'b1;
    repeat (3) @(negedge clk);
    expect_state("R1 reset", 0, 0, 0, 0, 0);
    s_valid = 1'b0; s_ready = 1'b0; s_sof = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_stream_frame();
    cfg_src = 1'b0; cfg_hsize = 16'd8; cfg_vsize = 13'd2;
    ext_sync = 1'b1; step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check("R2 ext_sync ignored in stream mode", int'(frm_start), 0);
    step(1, 1, 0, 1);
    expect_state("R2 first beat", 1, 0, 4, 0, 0);
    step(1, 1, 1, 0);
    expect_state("R5 tlast closes line", 0, 1, 8, 0, 0);
    step(1, 1, 0, 0);
    expect_state("R5 mid line", 0, 1, 12, 0, 0);
    step(1, 1, 0, 0);
    expect_state("R5 hsize closes line", 0, 2, 16, 0, 0);
    step(1, 1, 1, 0);
    expect_state("R6 beat after complete", 0, 2, 16, 0, 0);
  endtask

  task automatic t_zero_size();
    cfg_vsize = 13'd0;
    step(1, 1, 0, 1);
    expect_state("R8 vsize zero start", 1, 0, 0, 0, 1);
    step(1, 1, 0, 0);
    expect_state("R8 no count when inactive", 0, 0, 0, 0, 1);
    err_clr = 1'b1; step(0, 0, 0, 0);
    check("R9 clear size flag", int'(err_size), 0);
    cfg_vsize = 13'd2; cfg_hsize = 16'd0;
    step(1, 1, 0, 1);
    expect_state("R8 hsize zero start", 1, 0, 0, 0, 1);
    err_clr = 1'b1; step(0, 0, 0, 0);
    cfg_hsize = 16'd8;
  endtask

  task automatic t_backpressure();
    step(1, 1, 0, 1);
    expect_state("R10 restart", 1, 0, 4, 0, 0);
    step(1, 0, 0, 0);
    expect_state("R4 ready low", 0, 0, 4, 0, 0);
    step(0, 1, 1, 0);
    expect_state("R4 valid low", 0, 0, 4, 0, 0);
    step(1, 1, 0, 0);
    expect_state("R4 beat after stall", 0, 1, 8, 0, 0);
  endtask

  task automatic t_early_and_clear();
    step(1, 1, 0, 1);
    expect_state("R7 early stream start", 1, 0, 4, 1, 1);
    step(0, 0, 0, 0);
    expect_state("R9 flags held", 0, 0, 4, 1, 1);
    err_clr = 1'b1; step(0, 0, 0, 0);
    expect_state("R9 clear", 0, 0, 4, 0, 0);
    err_clr = 1'b1; step(1, 1, 0, 1);
    expect_state("R9 set wins over clear", 1, 0, 4, 1, 1);
    err_clr = 1'b1; step(0, 0, 0, 0);
  endtask

  task automatic t_ext_mode();
    cfg_src = 1'b1;
    ext_sync = 1'b1; step(0, 0, 0, 0);
    check("R3 no start while sync high", int'(frm_start), 0);
    step(0, 0, 0, 0);
    expect_state("R3 R7 ext early start", 1, 0, 0, 1, 1);
    err_clr = 1'b1; step(0, 0, 0, 0);
    step(1, 1, 0, 1);
    expect_state("R3 sof ignored in ext mode", 0, 0, 4, 0, 0);
    step(1, 1, 1, 0);
    step(1, 1, 1, 0);
    expect_state("R6 ext frame complete", 0, 2, 12, 0, 0);
    ext_sync = 1'b1; step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    expect_state("R7 on-time ext start no error", 1, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_stream_frame();
    t_zero_size();
    t_backpressure();
    t_early_and_clear();
    t_ext_mode();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule